// File: doc/BRIEF.md
# Quadrature Position Counter with One-Shot Capture

This block keeps a 32-bit position count from an incremental encoder. It decodes the A/B quadrature pair in 4x mode, counting once on every edge of either signal. An 8-bit control byte from the controller steers it. The byte can preset the counter from a 32-bit preset word. It can also arm a one-shot capture of the count into a latch register. The capture fires on a chosen edge of an external latch pin or on the rising edge of a zero-reference pin. The 32-bit data word returns either the live count or the captured value. An 8-bit status byte echoes commands and reports capture state.

All pin inputs pass through a synchronizer and then an edge detector before they act. A capture stays armed only until its first qualifying edge. After that edge the latch register keeps its value until the enable is withdrawn and given again. Optionally, an active latch edge also clears the counter. The latch then keeps the count from just before the clear.

Top module: `enc_latch_counter`

## Requirements
- R1: A single-bit change of the quad_a/quad_b pair moves the count by one. The count goes up when the change follows the order (a,b) = 00, 10, 11, 01 and down when it follows the reverse order. The count wraps modulo 2^32. A change of any pin input first affects the counter or latch at the third rising clock edge that samples the new level.
- R2: When quad_a and quad_b both change between two samples, the count does not change.
- R3: A 0-to-1 change of control bit 2 loads preset_word into the counter at that clock edge. Holding bit 2 high loads nothing more, and counting continues.
- R4: The data word shows the counter when control bit 1 is 0 and the latch register when it is 1.
- R5: While control bit 3 is set, the first rising edge of latch_in stores the count in the latch register. Later edges of latch_in change nothing until bits 3 and 4 have both been 0 for at least one clock.
- R6: While control bit 4 is set, the first falling edge of latch_in captures in the same one-shot way. Bits 3 and 4 share a single arming, so with both set the first active edge of either polarity wins.
- R7: While control bit 0 is set, the first rising edge of zero_in captures the count, once per arming. Status bit 0 is set from the clock after that capture. It clears at the first clock edge at which bit 0 is 0.
- R8: With control bit 5 set, every active edge chosen by bits 0, 3 and 4 clears the counter. When a capture falls on the same edge, the latch gets the count from before the clear. Across the functions that change the counter, the order of priority is preset, then clear, then count step.
- R9: The status byte has these fields:
  - bit 1 echoes the effective control bit 1, and bit 2 echoes the effective control bit 2;
  - bit 3 is set while a latch-pin capture has occurred under the current arming;
  - bit 4 flags the forbidden setting of bit 0 together with bit 3 or bit 4;
  - bits 5 and 6 read 0;
  - bit 7 echoes control bit 7.
- R10: While control bit 7 is 1, every other control bit is treated as 0, and counting goes on. Leaving that mode with bit 2 high counts as a 0-to-1 change of bit 2.
- R11: After reset the counter, the latch register and both capture flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| quad_a | input | 1 | Encoder channel A |
| quad_b | input | 1 | Encoder channel B |
| latch_in | input | 1 | External latch pin |
| zero_in | input | 1 | Zero-reference pin |
| ctrl_byte | input | 8 | Control byte from the controller |
| preset_word | input | 32 | Value loaded by the preset command |
| status_byte | output | 8 | Status byte to the controller |
| data_word | output | 32 | Live count or latch register |

## Verification
A preset command and a clear caused by a latch edge can reach the counter on the same clock edge, and a capture of the old count happens on that edge too. The bench provokes this by raising latch_in and then raising control bit 2 exactly two clocks later, so the synchronized latch edge and the control edge meet. The result is correct when the counter holds the preset value and the latch holds the count from before the edge. A reference model checks every clock, so count steps that meet a capture or a clear in the same cycle are judged in the same way.

// File: rtl/enc_pkg.sv
`timescale 1ns/1ps
package enc_pkg;

  typedef struct packed {
    logic reg_access;
    logic rsvd;
    logic clr_on_hit;
    logic arm_fall;
    logic arm_rise;
    logic set_cnt;
    logic show_latch;
    logic arm_zero;
  } ctrl_t;

  localparam int PIN_A    = 0;
  localparam int PIN_B    = 1;
  localparam int PIN_LAT  = 2;
  localparam int PIN_ZERO = 3;
  localparam int N_PINS   = 4;

endpackage

// File: rtl/enc_edge_sync.sv
`timescale 1ns/1ps
module enc_edge_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] prv,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);

  localparam int LAST = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [STAGES-1:0] shift_q;
    logic [STAGES-1:0] shift_d;
    logic              hist_q;

    always_comb begin
      shift_d = {shift_q[STAGES-2:0], din[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shift_q <= '0;
        hist_q  <= 1'b0;
      end else begin
        shift_q <= shift_d;
        hist_q  <= shift_q[LAST];
      end
    end

    assign lvl[g]  = shift_q[LAST];
    assign prv[g]  = hist_q;
    assign rise[g] = shift_q[LAST] & ~hist_q;
    assign fall[g] = ~shift_q[LAST] & hist_q;
  end

endmodule

// File: rtl/enc_quad_dec.sv
`timescale 1ns/1ps
module enc_quad_dec (
  input  logic a_now,
  input  logic b_now,
  input  logic a_old,
  input  logic b_old,
  output logic step_en,
  output logic step_up
);

  logic a_chg;
  logic b_chg;

  always_comb begin
    a_chg   = a_now ^ a_old;
    b_chg   = b_now ^ b_old;
    step_en = a_chg ^ b_chg;
    step_up = a_now ^ b_old;
  end

endmodule

// File: rtl/enc_capture.sv
`timescale 1ns/1ps
module enc_capture
  import enc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctl,
  input  logic             lat_rise,
  input  logic             lat_fall,
  input  logic             zero_rise,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] latch_val,
  output logic             cap_any,
  output logic             cap_zero,
  output logic             clr_hit,
  output logic             lat_valid,
  output logic             zero_valid
);

  logic hit_pin;
  logic hit_zero;
  logic cap_pin;
  logic pin_armed;
  logic lat_valid_d;
  logic zero_valid_d;
  logic [CNT_W-1:0] latch_d;

  always_comb begin
    pin_armed    = ctl.arm_rise | ctl.arm_fall;
    hit_pin      = (ctl.arm_rise & lat_rise) | (ctl.arm_fall & lat_fall);
    hit_zero     = ctl.arm_zero & zero_rise;
    cap_pin      = hit_pin & ~lat_valid;
    cap_zero     = hit_zero & ~zero_valid;
    cap_any      = cap_pin | cap_zero;
    clr_hit      = ctl.clr_on_hit & (hit_pin | hit_zero);
    lat_valid_d  = pin_armed & (lat_valid | cap_pin);
    zero_valid_d = ctl.arm_zero & (zero_valid | cap_zero);
    latch_d      = count;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_valid  <= 1'b0;
      zero_valid <= 1'b0;
    end else begin
      lat_valid  <= lat_valid_d;
      zero_valid <= zero_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_val <= '0;
    end else if (cap_any) begin
      latch_val <= latch_d;
    end
  end

endmodule

// File: rtl/enc_latch_counter.sv
`timescale 1ns/1ps
module enc_latch_counter
  import enc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             quad_a,
  input  logic             quad_b,
  input  logic             latch_in,
  input  logic             zero_in,
  input  logic [7:0]       ctrl_byte,
  input  logic [CNT_W-1:0] preset_word,
  output logic [7:0]       status_byte,
  output logic [CNT_W-1:0] data_word
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic rst_s1;
  logic rst_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1  <= 1'b0;
      rst_int <= 1'b0;
    end else begin
      rst_s1  <= 1'b1;
      rst_int <= rst_s1;
    end
  end

  ctrl_t ctl_raw;
  ctrl_t ctl;

  always_comb begin
    ctl_raw = ctrl_t'(ctrl_byte);
    ctl     = ctl_raw.reg_access ? ctrl_t'(8'h00) : ctl_raw;
  end

  logic [N_PINS-1:0] pin_lvl;
  logic [N_PINS-1:0] pin_prv;
  logic [N_PINS-1:0] pin_rise;
  logic [N_PINS-1:0] pin_fall;

  enc_edge_sync #(
    .WIDTH (N_PINS),
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_int),
    .din  ({zero_in, latch_in, quad_b, quad_a}),
    .lvl  (pin_lvl),
    .prv  (pin_prv),
    .rise (pin_rise),
    .fall (pin_fall)
  );

  logic step_en;
  logic step_up;

  enc_quad_dec u_dec (
    .a_now  (pin_lvl[PIN_A]),
    .b_now  (pin_lvl[PIN_B]),
    .a_old  (pin_prv[PIN_A]),
    .b_old  (pin_prv[PIN_B]),
    .step_en(step_en),
    .step_up(step_up)
  );

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] latch_val;
  logic             cap_any;
  logic             cap_zero;
  logic             clr_hit;
  logic             lat_valid;
  logic             zero_valid;

  enc_capture #(
    .CNT_W(CNT_W)
  ) u_cap (
    .clk       (clk),
    .rst_n     (rst_int),
    .ctl       (ctl),
    .lat_rise  (pin_rise[PIN_LAT]),
    .lat_fall  (pin_fall[PIN_LAT]),
    .zero_rise (pin_rise[PIN_ZERO]),
    .count     (count),
    .latch_val (latch_val),
    .cap_any   (cap_any),
    .cap_zero  (cap_zero),
    .clr_hit   (clr_hit),
    .lat_valid (lat_valid),
    .zero_valid(zero_valid)
  );

  logic             set_q;
  logic             preset_evt;
  logic             cnt_en;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    preset_evt = ctl.set_cnt & ~set_q;
    cnt_en     = preset_evt | clr_hit | step_en;
    if (preset_evt) begin
      count_d = preset_word;
    end else if (clr_hit) begin
      count_d = '0;
    end else if (step_up) begin
      count_d = count + ONE;
    end else begin
      count_d = count - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      set_q <= 1'b0;
    end else begin
      set_q <= ctl.set_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_int) begin
    if (!rst_int) begin
      count <= '0;
    end else if (cnt_en) begin
      count <= count_d;
    end
  end

  logic conflict;

  always_comb begin
    conflict    = ctl.arm_zero & (ctl.arm_rise | ctl.arm_fall);
    status_byte = {ctl_raw.reg_access, 2'b00, conflict, lat_valid,
                   ctl.set_cnt, ctl.show_latch, zero_valid};
    data_word   = ctl.show_latch ? latch_val : count;
  end

endmodule

// File: rtl/enc_latch_counter_chk.sv
`timescale 1ns/1ps
module enc_latch_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       ctrl_byte,
  input logic [CNT_W-1:0] preset_word,
  input logic [7:0]       status_byte,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] latch_val,
  input logic             cap_any,
  input logic             cap_zero,
  input logic             clr_hit,
  input logic             preset_evt
);

  AST_PRESET_LOAD: assert property (@(posedge clk) disable iff (!rst_n) preset_evt |=> count == $past(preset_word)); // R3
  AST_CAPTURE_VALUE: assert property (@(posedge clk) disable iff (!rst_n) cap_any |=> latch_val == $past(count)); // R5
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cap_any |=> $stable(latch_val)); // R5
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n) (!preset_evt && !clr_hit) |=> ((count - $past(count)) == CNT_W'(0) || (count - $past(count)) == CNT_W'(1) || (count - $past(count)) == {CNT_W{1'b1}})); // R1
  AST_CLEAR_WINS_STEP: assert property (@(posedge clk) disable iff (!rst_n) (clr_hit && !preset_evt) |=> count == '0); // R8
  AST_ZERO_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n) cap_zero |=> status_byte[0]); // R7
  AST_ZERO_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_byte[0] |=> !status_byte[0]); // R7
  AST_REGACC_LATCH: assert property (@(posedge clk) disable iff (!rst_n) ctrl_byte[7] |=> $stable(latch_val)); // R10

endmodule

bind enc_latch_counter enc_latch_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int),
  .ctrl_byte  (ctrl_byte),
  .preset_word(preset_word),
  .status_byte(status_byte),
  .count      (count),
  .latch_val  (latch_val),
  .cap_any    (cap_any),
  .cap_zero   (cap_zero),
  .clr_hit    (clr_hit),
  .preset_evt (preset_evt)
);

// File: tb/enc_latch_counter_bench.sv
`timescale 1ns/1ps
module enc_latch_counter_bench;

  logic        clk;
  logic        rst_n;
  logic        quad_a;
  logic        quad_b;
  logic        latch_in;
  logic        zero_in;
  logic [7:0]  ctrl_byte;
  logic [31:0] preset_word;
  logic [7:0]  status_byte;
  logic [31:0] data_word;

  enc_latch_counter u_enc_latch_counter (
    .clk        (clk),
    .rst_n      (rst_n),
    .quad_a     (quad_a),
    .quad_b     (quad_b),
    .latch_in   (latch_in),
    .zero_in    (zero_in),
    .ctrl_byte  (ctrl_byte),
    .preset_word(preset_word),
    .status_byte(status_byte),
    .data_word  (data_word)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] m_cnt, m_lat;
  bit          m_dl, m_dz, m_setq, m_r1, m_r2;
  logic [3:0]  hist[$];

  function automatic int gidx(logic a, logic b);
    case ({b, a})
      2'b00:   return 0;
      2'b01:   return 1;
      2'b11:   return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0;
      m_cnt = 0; m_lat = 0; m_dl = 0; m_dz = 0; m_setq = 0;
      hist = {4'b0, 4'b0, 4'b0};
    end else begin
      if (m_r2) begin
        logic [7:0] eff;
        logic [3:0] cur, prv;
        int d;
        bit lr, lf, zr, hit_l, hit_z;
        eff = ctrl_byte[7] ? 8'h00 : ctrl_byte;
        cur = hist[1];
        prv = hist[2];
        d   = (gidx(cur[0], cur[1]) - gidx(prv[0], prv[1]) + 4) % 4;
        lr  = cur[2] && !prv[2];
        lf  = !cur[2] && prv[2];
        zr  = cur[3] && !prv[3];
        hit_l = (eff[3] && lr) || (eff[4] && lf);
        hit_z = eff[0] && zr;
        if ((hit_l && !m_dl) || (hit_z && !m_dz)) m_lat = m_cnt;
        if (!(eff[3] || eff[4])) m_dl = 0; else if (hit_l) m_dl = 1;
        if (!eff[0]) m_dz = 0; else if (hit_z) m_dz = 1;
        if (eff[2] && !m_setq)             m_cnt = preset_word;
        else if (eff[5] && (hit_l || hit_z)) m_cnt = 0;
        else if (d == 1)                   m_cnt = m_cnt + 1;
        else if (d == 3)                   m_cnt = m_cnt - 1;
        m_setq = eff[2];
        hist.push_front({zero_in, latch_in, quad_b, quad_a});
        void'(hist.pop_back());
      end
      m_r2 = m_r1;
      m_r1 = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      logic [7:0] eff;
      logic [7:0] m_st;
      eff  = ctrl_byte[7] ? 8'h00 : ctrl_byte;
      m_st = {ctrl_byte[7], 2'b00, eff[0] && (eff[3] || eff[4]), m_dl, eff[2], eff[1], m_dz};
      chk(eff[1] ? "R4 model latch view" : "R1 model count view", data_word, eff[1] ? m_lat : m_cnt);
      chk("R9 model status", {24'h0, status_byte}, {24'h0, m_st});
    end
  end

  // ---------------- stimulus ----------------
  int gi = 0;

  task automatic drive_q();
    quad_a = (gi == 1 || gi == 2);
    quad_b = (gi == 2 || gi == 3);
  endtask

  task automatic qstep(input bit up);
    @(posedge clk); #1;
    gi = up ? (gi + 1) % 4 : (gi + 3) % 4;
    drive_q();
    @(posedge clk);
  endtask

  task automatic set_ctrl(input logic [7:0] v);
    @(posedge clk); #1;
    ctrl_byte = v;
  endtask

  task automatic pulse(input bit zero);
    @(posedge clk); #1;
    if (zero) zero_in = 1; else latch_in = 1;
    repeat (3) @(posedge clk);
    #1;
    if (zero) zero_in = 0; else latch_in = 0;
    repeat (3) @(posedge clk);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; quad_a = 0; quad_b = 0; latch_in = 0; zero_in = 0;
    ctrl_byte = 8'h00; preset_word = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    settle();
    chk("R11 reset count", data_word, 32'h0);
    chk("R11 reset status", {24'h0, status_byte}, 32'h0);

    repeat (10) qstep(1);
    settle();
    chk("R1 count up", data_word, 32'd10);
    repeat (15) qstep(0);
    settle();
    chk("R1 wrap below zero", data_word, 32'hFFFF_FFFB);

    @(posedge clk); #1;
    gi = (gi + 2) % 4;
    drive_q();
    settle();
    chk("R2 double change ignored", data_word, 32'hFFFF_FFFB);

    preset_word = 32'h7FFF_FFF0;
    set_ctrl(8'h04);
    settle();
    chk("R3 preset load", data_word, 32'h7FFF_FFF0);
    chk("R9 set echo", {31'h0, status_byte[2]}, 32'h1);
    repeat (3) qstep(1);
    settle();
    chk("R3 held bit no reload", data_word, 32'h7FFF_FFF3);

    set_ctrl(8'h0C);
    pulse(0);
    set_ctrl(8'h0E);
    settle();
    chk("R4 latch view", data_word, 32'h7FFF_FFF3);
    chk("R9 status flags", {24'h0, status_byte}, 32'h0E);
    set_ctrl(8'h0C);
    repeat (2) qstep(1);
    pulse(0);
    set_ctrl(8'h0E);
    settle();
    chk("R5 second edge ignored", data_word, 32'h7FFF_FFF3);
    set_ctrl(8'h0C);
    settle();
    chk("R4 count view", data_word, 32'h7FFF_FFF5);
    set_ctrl(8'h04);
    settle();
    chk("R5 flag cleared on disarm", {31'h0, status_byte[3]}, 32'h0);
    set_ctrl(8'h0C);
    pulse(0);
    set_ctrl(8'h0E);
    settle();
    chk("R5 rearm captures", data_word, 32'h7FFF_FFF5);

    set_ctrl(8'h04);
    @(posedge clk); #1 latch_in = 1;
    repeat (3) @(posedge clk);
    set_ctrl(8'h14);
    qstep(1);
    qstep(1);
    @(posedge clk); #1 latch_in = 0;
    set_ctrl(8'h16);
    settle();
    chk("R6 falling capture", data_word, 32'h7FFF_FFF7);

    set_ctrl(8'h04);
    set_ctrl(8'h05);
    qstep(1);
    pulse(1);
    qstep(1);
    pulse(1);
    set_ctrl(8'h07);
    settle();
    chk("R7 zero capture once", data_word, 32'h7FFF_FFF8);
    chk("R7 zero flag set", {31'h0, status_byte[0]}, 32'h1);
    set_ctrl(8'h06);
    settle();
    chk("R7 zero flag cleared", {31'h0, status_byte[0]}, 32'h0);

    set_ctrl(8'h2C);
    pulse(0);
    settle();
    chk("R8 counter cleared", data_word, 32'h0);
    set_ctrl(8'h2E);
    settle();
    chk("R8 pre-clear count latched", data_word, 32'h7FFF_FFF9);
    set_ctrl(8'h2C);
    repeat (2) qstep(1);
    pulse(0);
    settle();
    chk("R8 every edge clears", data_word, 32'h0);

    set_ctrl(8'h09);
    settle();
    chk("R9 conflict flag", {31'h0, status_byte[4]}, 32'h1);
    chk("R9 reserved bits", {30'h0, status_byte[6:5]}, 32'h0);

    preset_word = 32'h1234_5678;
    set_ctrl(8'h84);
    settle();
    chk("R10 commands masked", data_word, 32'h0);
    chk("R10 status echo", {24'h0, status_byte}, 32'h80);
    qstep(1);
    settle();
    chk("R10 counting continues", data_word, 32'h1);
    set_ctrl(8'h04);
    settle();
    chk("R10 exit acts as set edge", data_word, 32'h1234_5678);

    set_ctrl(8'h00);
    set_ctrl(8'h28);
    preset_word = 32'hAAAA_0000;
    @(posedge clk); #1 latch_in = 1;
    @(posedge clk);
    @(posedge clk); #1 ctrl_byte = 8'h2C;
    settle();
    chk("R8 preset beats clear", data_word, 32'hAAAA_0000);
    set_ctrl(8'h2E);
    settle();
    chk("R8 capture on collision", data_word, 32'h1234_5678);
    @(posedge clk); #1 latch_in = 0;
    settle();

    finish_run();
  end

endmodule